// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address by reading the page tables in memory, one level at a time. It works in long mode with either four levels (48-bit virtual space) or five levels (57-bit virtual space). A mode input picks the depth. The caller provides the virtual address, the root table pointer, an address-wrap mask and the mode, then pulses `start`.

The walker first checks that the address is canonical for the chosen depth. It then reads one 64-bit entry per level over a single-outstanding memory port. When an entry's accessed flag is clear, it writes the entry back with that flag set. It combines the user, write and execute rights of every level it visits. Large pages end the walk early at the 1 GiB or 2 MiB level. When the walk ends, a one-cycle `done` pulse reports the result: either a physical address with its rights, or a fault code.

A small watcher sits beside the walker on the control-register write path. It raises a TLB-flush strobe when a write toggles any bit that changes how translation works.

Top module: `pgwalk_unit`

## Requirements
- R1: The canonical check runs before any memory request. With `mode5`=1, bits 63:56 of `va` must all be equal. With `mode5`=0, bits 63:47 must all be equal. On a mismatch, `done` reports `fault`=1 (general protection) and the walker issues no memory request.
- R2: With `mode5`=1, the first read goes to (`root` with bits 11:0 cleared) OR (`va[56:48]` × 8), ANDed with `wrap_mask`.
- R3: With `mode5`=0, the first read goes to (`root` bits 51:12, with bits 11:0 zero) + `va[47:39]` × 8. The next levels use indices `va[38:30]`, `va[29:21]` and `va[20:12]`. Each of these levels is based on bits 51:12 of the previous entry. Every entry address is ANDed with `wrap_mask`.
- R4: An entry with bit 0 (present) clear ends the walk with `fault`=2. That entry is not written back.
- R5: At the five-level top or at the 4th level, an entry with any of bits 62:52 set, or with bit 7 (page size) set, ends the walk with `fault`=3. That entry is not written back.
- R6: A valid entry with bit 5 (accessed) clear is written back to its own address with bit 5 set, before the next level is read. An entry that already has bit 5 set causes no write.
- R7: `perm` = {exec, write, user}. Each of these is the AND, over all visited levels, of NOT bit 63, bit 1 and bit 2 respectively. The AND starts from all ones, so a four-level walk starts fully permitted.
- R8: If bit 7 is set at the 3rd level, the walk ends with `pa` = {entry[51:30], va[29:0]}. If bit 7 is set at the 2nd level, `pa` = {entry[51:21], va[20:0]}. Otherwise the walk ends at the last level with `pa` = {entry[51:12], va[11:0]}.
- R9: `mem_req` is high for exactly one cycle per access, and a new request waits for `mem_rvalid`. Writes are acknowledged by `mem_rvalid` as well.
- R10: `done` is a one-cycle pulse. Fault codes are 0 = none, 1 = general protection, 2 = not present and 3 = reserved. On any fault, `pa` and `perm` are zero.
- R11: `flush` is high in the cycle of a `cr_wr` whose `cr_wdata` differs from the held value in any of bits 4, 5, 7, 12, 20 or 21. The held value resets to 0 and is loaded on every write.
- R12: `start` is ignored while `busy` or `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk with the inputs below |
| va | input | 64 | Virtual address to translate |
| root | input | 64 | Root table pointer |
| mode5 | input | 1 | 1 = five-level, 0 = four-level |
| wrap_mask | input | 64 | AND mask applied to every entry address |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| pa | output | 64 | Translated physical address |
| perm | output | 3 | {exec, write, user} |
| fault | output | 2 | Fault code |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Entry address |
| mem_wdata | output | 64 | Write-back data |
| mem_rvalid | input | 1 | Response or write acknowledge |
| mem_rdata | input | 64 | Read data |
| cr_wr | input | 1 | Control-register write strobe |
| cr_wdata | input | 32 | New control-register value |
| flush | output | 1 | TLB flush strobe |

## Verification
A full four-level walk to a 4 KiB page is compared with a five-level walk of the same lower tables. This separates the extra top level, the way its base is taken and the read count. Walks that end early at the 2 MiB and 1 GiB levels show which address bits come from the entry and which pass through from `va`. Addresses that are canonical in one mode but not in the other show that the check width follows `mode5`. Tables placed behind a cleared `wrap_mask` bit, entries with the accessed, user, write or no-execute flags varied, and not-present or reserved entries at chosen levels each isolate one decision of the walk. Control-register writes that toggle watched bits, unwatched bits or nothing show which changes raise `flush`.

// File: rtl/pgwalk_pkg.sv
// Shared definitions for the page table walker: entry bit positions,
// fault codes and walk states.
package pgwalk_pkg;

    localparam int B_PRESENT  = 0;
    localparam int B_WRITE    = 1;
    localparam int B_USER     = 2;
    localparam int B_ACCESSED = 5;
    localparam int B_BIGPAGE  = 7;
    localparam int B_NOEXEC   = 63;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_NP   = 2'd2,
        FLT_RSV  = 2'd3
    } flt_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD,
        S_RW,
        S_WR,
        S_WW,
        S_ADV
    } walk_st_e;

endpackage

// File: rtl/pgwalk_canon.sv
// Canonical-address test.
// Checks that the unused upper bits of the virtual address are a sign
// extension of the top translated bit: bit 56 in five-level mode, bit 47
// in four-level mode. Purely combinational.
module pgwalk_canon (
    input  logic [63:0] va,
    input  logic        mode5,
    output logic        ok
);
    logic unused_low;

    // Sign-extension test for the selected depth.
    always_comb begin
        if (mode5) ok = (&va[63:56]) | ~(|va[63:56]);
        else       ok = (&va[63:47]) | ~(|va[63:47]);
    end

    assign unused_low = ^va[46:0];
endmodule

// File: rtl/pgwalk_entry.sv
// Entry decoder.
// Splits one table entry into the flags the walk controller needs,
// given the level it was read at (5 = top, 1 = last).
// Assumes lvl is 1..5.
module pgwalk_entry
    import pgwalk_pkg::*;
#(
    parameter int PA_BITS = 52
) (
    input  logic [63:0] ent,
    input  logic [2:0]  lvl,
    output logic        present,
    output logic        accessed,
    output logic        rsvd_hit,
    output logic        leaf,
    output logic [2:0]  grant
);
    localparam logic [63:0] RSVD_M = ~((64'd1 << PA_BITS) - 64'd1) & ~(64'd1 << B_NOEXEC);

    // Flag extraction and level-dependent classification.
    always_comb begin
        present  = ent[B_PRESENT];
        accessed = ent[B_ACCESSED];
        rsvd_hit = (lvl >= 3'd4) && ((|(ent & RSVD_M)) || ent[B_BIGPAGE]);
        leaf     = (lvl == 3'd1) || (((lvl == 3'd2) || (lvl == 3'd3)) && ent[B_BIGPAGE]);
        grant    = {~ent[B_NOEXEC], ent[B_WRITE], ent[B_USER]};
    end
endmodule

// File: rtl/pgwalk_addr.sv
// Address arithmetic.
// Forms the entry address for the current level from the table base and
// the virtual-address index, and forms the final physical address when
// the entry at this level is a leaf. Assumes lvl is 1..5.
module pgwalk_addr #(
    parameter int PA_BITS  = 52,
    parameter int IDX_W    = 9,
    parameter int PG_SHIFT = 12
) (
    input  logic [63:0] base,
    input  logic [63:0] va,
    input  logic [63:0] mask,
    input  logic [63:0] ent,
    input  logic [2:0]  lvl,
    output logic [63:0] ent_addr,
    output logic [63:0] leaf_pa
);
    localparam int          ENT_SHIFT = 3;
    localparam logic [63:0] FIELD_M   = ((64'd1 << PA_BITS) - 64'd1) &
                                        ~((64'd1 << PG_SHIFT) - 64'd1);

    int                 sh;
    logic [IDX_W-1:0]   idx;
    logic [63:0]        off_m;

    // Index position and page-offset mask for this level.
    always_comb begin
        sh    = (lvl == 3'd0) ? PG_SHIFT : PG_SHIFT + IDX_W * (int'(lvl) - 1);
        idx   = IDX_W'(va >> sh);
        off_m = (64'd1 << sh) - 64'd1;
    end

    // Entry address and leaf translation.
    always_comb begin
        ent_addr = (base | (64'(idx) << ENT_SHIFT)) & mask;
        leaf_pa  = ((ent & FIELD_M) & ~off_m) | (va & off_m);
    end
endmodule

// File: rtl/pgwalk_flush.sv
// Control-register change watcher.
// Holds the last written control value and raises flush in the same
// cycle as a write that toggles any translation-relevant bit.
module pgwalk_flush #(
    parameter int CR_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cr_wr,
    input  logic [CR_W-1:0] cr_wdata,
    output logic            flush
);
    localparam logic [CR_W-1:0] WATCH_M = (CR_W'(1) << 4)  | (CR_W'(1) << 5)  |
                                          (CR_W'(1) << 7)  | (CR_W'(1) << 12) |
                                          (CR_W'(1) << 20) | (CR_W'(1) << 21);

    logic [CR_W-1:0] cr_q;

    // Keep the last written value.
    always_ff @(posedge clk) begin
        if (!rst_n)     cr_q <= '0;
        else if (cr_wr) cr_q <= cr_wdata;
    end

    // Compare the new value against the held value on watched bits.
    always_comb flush = cr_wr && (|((cr_wdata ^ cr_q) & WATCH_M));
endmodule

// File: rtl/pgwalk_unit.sv
// Multi-level page table walker, top level.
// Accepts a walk when idle. It checks canonicality, then reads one entry
// per level through a single-outstanding request port, writing back the
// accessed flag where needed. It ends with a one-cycle done pulse that
// carries a physical address, rights and a fault code. Assumes the memory
// answers each request with exactly one mem_rvalid, at least one cycle later.
module pgwalk_unit
    import pgwalk_pkg::*;
#(
    parameter int PA_BITS  = 52,
    parameter int IDX_W    = 9,
    parameter int PG_SHIFT = 12,
    parameter int CR_W     = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [63:0]     va,
    input  logic [63:0]     root,
    input  logic            mode5,
    input  logic [63:0]     wrap_mask,
    output logic            busy,
    output logic            done,
    output logic [63:0]     pa,
    output logic [2:0]      perm,
    output logic [1:0]      fault,
    output logic            mem_req,
    output logic            mem_we,
    output logic [63:0]     mem_addr,
    output logic [63:0]     mem_wdata,
    input  logic            mem_rvalid,
    input  logic [63:0]     mem_rdata,
    input  logic            cr_wr,
    input  logic [CR_W-1:0] cr_wdata,
    output logic            flush
);
    localparam logic [63:0] FIELD_M = ((64'd1 << PA_BITS) - 64'd1) &
                                      ~((64'd1 << PG_SHIFT) - 64'd1);
    localparam logic [63:0] LOW_M   = (64'd1 << PG_SHIFT) - 64'd1;

    walk_st_e    st;
    logic [2:0]  lvl;
    logic [63:0] va_q, mask_q, base_q, ent_q, pa_q;
    logic [2:0]  acc_q, perm_q;
    flt_e        flt_q;
    logic        done_q;

    logic        canon_ok;
    logic [63:0] ent_src, ent_addr, leaf_pa;
    logic        e_present, e_accessed, e_rsvd, e_leaf;
    logic [2:0]  e_grant;

    pgwalk_canon u_canon (
        .va    (va),
        .mode5 (mode5),
        .ok    (canon_ok)
    );

    // Decode the fresh response while waiting for it, else the held entry.
    always_comb ent_src = (st == S_RW) ? mem_rdata : ent_q;

    pgwalk_entry #(.PA_BITS(PA_BITS)) u_entry (
        .ent      (ent_src),
        .lvl      (lvl),
        .present  (e_present),
        .accessed (e_accessed),
        .rsvd_hit (e_rsvd),
        .leaf     (e_leaf),
        .grant    (e_grant)
    );

    pgwalk_addr #(.PA_BITS(PA_BITS), .IDX_W(IDX_W), .PG_SHIFT(PG_SHIFT)) u_addr (
        .base     (base_q),
        .va       (va_q),
        .mask     (mask_q),
        .ent      (ent_q),
        .lvl      (lvl),
        .ent_addr (ent_addr),
        .leaf_pa  (leaf_pa)
    );

    pgwalk_flush #(.CR_W(CR_W)) u_flush (
        .clk      (clk),
        .rst_n    (rst_n),
        .cr_wr    (cr_wr),
        .cr_wdata (cr_wdata),
        .flush    (flush)
    );

    // Walk controller: sequencing, permission accumulation and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            lvl    <= 3'd0;
            va_q   <= '0;
            mask_q <= '0;
            base_q <= '0;
            ent_q  <= '0;
            acc_q  <= 3'b111;
            pa_q   <= '0;
            perm_q <= '0;
            flt_q  <= FLT_NONE;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start && !done_q) begin
                        va_q   <= va;
                        mask_q <= wrap_mask;
                        acc_q  <= 3'b111;
                        if (!canon_ok) begin
                            done_q <= 1'b1;
                            flt_q  <= FLT_GP;
                            pa_q   <= '0;
                            perm_q <= '0;
                        end else begin
                            lvl    <= mode5 ? 3'd5 : 3'd4;
                            base_q <= mode5 ? (root & ~LOW_M) : (root & FIELD_M);
                            st     <= S_RD;
                        end
                    end
                end
                S_RD: st <= S_RW;
                S_RW: begin
                    if (mem_rvalid) begin
                        ent_q <= mem_rdata;
                        if (!e_present || e_rsvd) begin
                            done_q <= 1'b1;
                            flt_q  <= e_present ? FLT_RSV : FLT_NP;
                            pa_q   <= '0;
                            perm_q <= '0;
                            st     <= S_IDLE;
                        end else begin
                            acc_q <= acc_q & e_grant;
                            st    <= e_accessed ? S_ADV : S_WR;
                        end
                    end
                end
                S_WR: st <= S_WW;
                S_WW: begin
                    if (mem_rvalid) st <= S_ADV;
                end
                S_ADV: begin
                    if (e_leaf) begin
                        done_q <= 1'b1;
                        flt_q  <= FLT_NONE;
                        pa_q   <= leaf_pa;
                        perm_q <= acc_q;
                        st     <= S_IDLE;
                    end else begin
                        base_q <= ent_q & FIELD_M;
                        lvl    <= lvl - 3'd1;
                        st     <= S_RD;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Memory port and result outputs.
    always_comb begin
        mem_req   = (st == S_RD) || (st == S_WR);
        mem_we    = (st == S_WR);
        mem_addr  = ent_addr;
        mem_wdata = ent_q | (64'd1 << B_ACCESSED);
        busy      = (st != S_IDLE);
        done      = done_q;
        pa        = pa_q;
        perm      = perm_q;
        fault     = flt_q;
    end
endmodule

// File: rtl/pgwalk_unit_chk.sv
// Assertion checker for pgwalk_unit, attached by bind.
// Observes ports only.
module pgwalk_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic [63:0] pa,
    input logic [2:0]  perm,
    input logic [1:0]  fault,
    input logic        mem_req,
    input logic        mem_we,
    input logic [63:0] mem_wdata,
    input logic        cr_wr,
    input logic        flush
);
    // R9: a request lasts one cycle.
    a_r9_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R9: requests only during a walk.
    a_r9_req_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R10: done is a single-cycle pulse.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: faulted results carry zero address and rights.
    a_r10_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 2'd0) |-> (pa == 64'd0 && perm == 3'd0));

    // R1: a protection fault comes straight from idle, with no walk.
    a_r1_gp_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault == 2'd1) |-> !$past(busy));

    // R6: every write-back carries the accessed flag.
    a_r6_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[5]);

    // R11: flush only with a control write.
    a_r11_flush_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> cr_wr);
endmodule

bind pgwalk_unit pgwalk_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .pa        (pa),
    .perm      (perm),
    .fault     (fault),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .cr_wr     (cr_wr),
    .flush     (flush)
);

// File: tb/pgwalk_unit_bench.sv
// Directed bench for pgwalk_unit with a sparse memory model.
module pgwalk_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] FP = 64'h1, FW = 64'h2, FU = 64'h4, FA = 64'h20,
                            FPS = 64'h80, FNX = 64'h1 << 63;
    localparam logic [63:0] OKF  = FP | FW | FU | FA;
    localparam logic [63:0] ALL1 = '1;
    localparam logic [63:0] VA4 = (64'd1 << 39) | (64'd2 << 30) | (64'd3 << 21) |
                                  (64'd4 << 12) | 64'h567;
    localparam logic [63:0] VA5 = VA4 | (64'd5 << 48);

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode5 = 1'b0;
    logic [63:0] va = '0, root = '0, wrap_mask = '1;
    logic        busy, done, mem_req, mem_we, flush;
    logic [63:0] pa, mem_addr, mem_wdata;
    logic [2:0]  perm;
    logic [1:0]  fault;
    logic        m_rvalid = 1'b0;
    logic [63:0] m_rdata = '0;
    logic        cr_wr = 1'b0;
    logic [31:0] cr_wdata = '0;

    logic [63:0] mem [logic [63:0]];
    int          n_rd, n_wr;
    logic [63:0] first_rd;
    int          n_chk = 0, n_bad = 0, cyc = 0;
    logic [63:0] r_pa;
    logic [2:0]  r_perm;
    logic [1:0]  r_fault;

    pgwalk_unit u_pgwalk_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .va(va), .root(root),
        .mode5(mode5), .wrap_mask(wrap_mask), .busy(busy), .done(done),
        .pa(pa), .perm(perm), .fault(fault), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(m_rvalid), .mem_rdata(m_rdata), .cr_wr(cr_wr),
        .cr_wdata(cr_wdata), .flush(flush)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Memory model: answers each request one cycle later.
    always @(posedge clk) begin
        m_rvalid <= 1'b0;
        if (mem_req) begin
            m_rvalid <= 1'b1;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                n_wr = n_wr + 1;
            end else begin
                m_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'd0;
                if (n_rd == 0) first_rd = mem_addr;
                n_rd = n_rd + 1;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rd_mem(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    task automatic clear_mem();
        mem.delete();
        n_rd = 0;
        n_wr = 0;
        first_rd = '1;
    endtask

    // Four-level chain for VA4 below the given 4th-level table.
    task automatic chain4(input logic [63:0] base, input logic [63:0] f4,
                          input logic [63:0] f3, input logic [63:0] f2,
                          input logic [63:0] f1);
        mem[base + 64'h8] = 64'h2000 | f4;
        mem[64'h2010]     = 64'h3000 | f3;
        mem[64'h3018]     = 64'h4000 | f2;
        mem[64'h4020]     = 64'hABC000 | f1;
    endtask

    task automatic kick(input logic [63:0] v, input logic [63:0] r,
                        input logic m5, input logic [63:0] m);
        @(negedge clk);
        va = v; root = r; mode5 = m5; wrap_mask = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        for (int i = 0; i < 300; i++) begin
            if (done) begin
                r_pa = pa; r_perm = perm; r_fault = fault;
                return;
            end
            @(negedge clk);
        end
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL %s: actual no done expected done", tag);
        r_pa = '1; r_perm = '1; r_fault = '1;
    endtask

    task automatic walk(input string tag, input logic [63:0] v, input logic [63:0] r,
                        input logic m5, input logic [63:0] m);
        kick(v, r, m5, m);
        wait_done(tag);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10 reset done", 64'(done), 0);
        check("R9 reset busy/req", {62'd0, busy, mem_req}, 0);
        check("R11 reset flush", 64'(flush), 0);
    endtask

    task automatic t_walk4k();
        clear_mem();
        chain4(64'h1000, FP | FW | FU, OKF, OKF, OKF);
        walk("R3 4k", VA4, 64'h1000, 1'b0, ALL1);
        check("R3 4k first read", first_rd, 64'h1008);
        check("R3 4k reads", 64'(n_rd), 4);
        check("R8 4k pa", r_pa, 64'hABC567);
        check("R7 4k seeded perm", 64'(r_perm), 3'b111);
        check("R10 4k fault", 64'(r_fault), 0);
        check("R6 4k one write", 64'(n_wr), 1);
        check("R6 4k wb value", rd_mem(64'h1008), 64'h2027);
    endtask

    task automatic t_walk5();
        clear_mem();
        mem[64'h1028] = 64'h5000 | OKF;
        chain4(64'h5000, OKF, OKF, OKF, OKF | FNX);
        walk("R2 5lvl", VA5, 64'h1ABC, 1'b1, ALL1);
        check("R2 5lvl first read", first_rd, 64'h1028);
        check("R2 5lvl reads", 64'(n_rd), 5);
        check("R8 5lvl pa", r_pa, 64'hABC567);
        check("R7 5lvl nx perm", 64'(r_perm), 3'b011);
        check("R6 5lvl no write", 64'(n_wr), 0);
    endtask

    task automatic t_perm();
        clear_mem();
        chain4(64'h1000, OKF, FP | FW | FA, OKF, FP | FU | FA);
        walk("R7 perm", VA4, 64'h1000, 1'b0, ALL1);
        check("R7 perm mix", 64'(r_perm), 3'b100);
    endtask

    task automatic t_big();
        clear_mem();
        chain4(64'h1000, OKF, OKF, OKF, OKF);
        mem[64'h3018] = 64'h40600000 | OKF | FPS;
        walk("R8 2m", VA4, 64'h1000, 1'b0, ALL1);
        check("R8 2m pa", r_pa, 64'h40604567);
        check("R8 2m reads", 64'(n_rd), 3);
        clear_mem();
        chain4(64'h1000, OKF, OKF, OKF, OKF);
        mem[64'h2010] = 64'h80000000 | OKF | FPS;
        walk("R8 1g", VA4, 64'h1000, 1'b0, ALL1);
        check("R8 1g pa", r_pa, 64'h80604567);
        check("R8 1g reads", 64'(n_rd), 2);
    endtask

    task automatic t_canon();
        clear_mem();
        walk("R1 gp4", 64'h0000_8000_0000_0000, 64'h1000, 1'b0, ALL1);
        check("R1 gp4 fault", 64'(r_fault), 1);
        check("R1 gp4 no reads", 64'(n_rd), 0);
        check("R10 gp4 zero pa", r_pa, 0);
        clear_mem();
        walk("R1 ok5", 64'h0000_8000_0000_0000, 64'h1000, 1'b1, ALL1);
        check("R1 same va canonical in 5lvl", 64'(r_fault), 2);
        check("R1 ok5 reads", 64'(n_rd), 1);
        clear_mem();
        walk("R1 gp5", 64'h0100_0000_0000_0000, 64'h1000, 1'b1, ALL1);
        check("R1 gp5 fault", 64'(r_fault), 1);
        check("R1 gp5 no reads", 64'(n_rd), 0);
        clear_mem();
        walk("R1 neg4", 64'hFFFF_8000_0000_0000, 64'h1000, 1'b0, ALL1);
        check("R1 negative canonical", 64'(r_fault), 2);
    endtask

    task automatic t_notpresent();
        clear_mem();
        chain4(64'h1000, OKF, OKF, FW | FU, OKF);
        walk("R4 np", VA4, 64'h1000, 1'b0, ALL1);
        check("R4 np fault", 64'(r_fault), 2);
        check("R4 np reads", 64'(n_rd), 3);
        check("R4 np no write", 64'(n_wr), 0);
        check("R10 np zero perm", 64'(r_perm), 0);
    endtask

    task automatic t_reserved();
        clear_mem();
        chain4(64'h1000, FP | FW | FU | (64'd1 << 52), OKF, OKF, OKF);
        walk("R5 rsv bit", VA4, 64'h1000, 1'b0, ALL1);
        check("R5 rsv bit fault", 64'(r_fault), 3);
        check("R5 rsv reads", 64'(n_rd), 1);
        check("R5 rsv no write", 64'(n_wr), 0);
        clear_mem();
        chain4(64'h1000, OKF | FPS, OKF, OKF, OKF);
        walk("R5 ps l4", VA4, 64'h1000, 1'b0, ALL1);
        check("R5 ps at 4th level", 64'(r_fault), 3);
        clear_mem();
        mem[64'h1028] = 64'h5000 | OKF | FPS;
        walk("R5 ps top", VA5, 64'h1000, 1'b1, ALL1);
        check("R5 ps at top", 64'(r_fault), 3);
        check("R5 ps top reads", 64'(n_rd), 1);
    endtask

    task automatic t_wrap();
        clear_mem();
        chain4(64'h1000, OKF, OKF, OKF, OKF);
        mem[64'h1008] = 64'h102000 | OKF;
        walk("R3 wrap", VA4, 64'h1000, 1'b0, ~(64'd1 << 20));
        check("R3 wrap fault", 64'(r_fault), 0);
        check("R3 wrap pa", r_pa, 64'hABC567);
    endtask

    task automatic t_busy_start();
        clear_mem();
        chain4(64'h1000, OKF, OKF, OKF, OKF);
        kick(VA4, 64'h1000, 1'b0, ALL1);
        @(negedge clk);
        start = 1'b1; va = 64'h0000_8000_0000_0000;
        @(negedge clk);
        start = 1'b0;
        wait_done("R12 busy start");
        check("R12 first walk kept", r_pa, 64'hABC567);
        check("R12 no gp", 64'(r_fault), 0);
        begin
            int extra = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (done) extra = extra + 1;
            end
            check("R12 no second done", 64'(extra), 0);
        end
    endtask

    task automatic cr_write(input string tag, input logic [31:0] v, input logic exp);
        @(negedge clk);
        cr_wr = 1'b1; cr_wdata = v;
        #1;
        check(tag, 64'(flush), 64'(exp));
        @(negedge clk);
        cr_wr = 1'b0;
    endtask

    task automatic t_flush();
        cr_write("R11 bit12 set", 32'h0000_1000, 1'b1);
        cr_write("R11 bit3 only", 32'h0000_1008, 1'b0);
        cr_write("R11 unchanged", 32'h0000_1008, 1'b0);
        cr_write("R11 bit20 set", 32'h0010_1008, 1'b1);
        cr_write("R11 bit4 set", 32'h0010_1018, 1'b1);
        cr_write("R11 bit12 clear", 32'h0010_0018, 1'b1);
        @(negedge clk);
        cr_wdata = 32'h0;
        #1;
        check("R11 no write no flush", 64'(flush), 0);
    endtask

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_walk4k();
        t_walk5();
        t_perm();
        t_big();
        t_canon();
        t_notpresent();
        t_reserved();
        t_wrap();
        t_busy_start();
        t_flush();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule